// File: doc/BRIEF.md
# 4:2:2 Pixel Input Demultiplexer with Byte-Serial and Split-Lane Modes

This block sits at the pixel input of a video pipeline. It takes 4:2:2 YCbCr samples from a 16-bit bus and produces co-sited pixels. Each output pixel carries one luma value, a Cb value, a Cr value, a valid strobe, an odd/even flag and the index of its pixel pair within the line. The bus runs in one of two modes:

- **Byte-serial mode:** one component arrives per clock on the low byte lane.
- **Split-lane mode:** luma arrives on the low byte lane and chroma on the high byte lane, and the bus is sampled only on every second clock.

Both modes give the same output cadence. Over each group of four clocks, the even pixel and then the odd pixel appear on two consecutive cycles.

A start-of-active-video strobe realigns the block and samples the requested mode. Between strobes the mode pin has no effect, so changing it cannot misalign a line. The output side is a valid-only stream with no ready signal. The pixel source is a free-running video bus that cannot be stalled, so the downstream consumer must accept every beat in the cycle it is presented. Beats are never repeated or held back.

Top module: `pxdemux`

## Requirements
- R1: After reset, `out_valid_o` is 0 and all data outputs are 0. The block starts in byte-serial mode (`mode_16_i`=0 encoding) with its phase at the first Cb, exactly as if a strobe selecting byte-serial mode had occurred in the last reset cycle.
- R2: In byte-serial mode, one component is taken from `pix_i[7:0]` on each rising edge, in the repeating order Cb, Y(even), Cr, Y(odd). `pix_i[15:8]` has no effect in this mode.
- R3: In split-lane mode, the bus is taken only on the first and third edges of each four-edge group. The first sample gives Cb on `pix_i[15:8]` and the even Y on `pix_i[7:0]`. The third sample gives Cr on `pix_i[15:8]` and the odd Y on `pix_i[7:0]`. The bus in the second and fourth cycles has no effect.
- R4: When `sav_i` is high in a cycle, the bus value in that cycle is ignored and the phase returns to the start. The next captured item is Cb (byte-serial mode) or the Cb/Y pair (split-lane mode). `out_valid_o` is 0 for the three cycles after the strobe edge.
- R5: The even pixel appears, with `out_odd_o`=0, in the cycle after the edge that captures Cr. It carries the even Y, the Cb and the Cr of that pair. The cycle after an odd pixel never carries a valid pixel.
- R6: The odd pixel appears, with `out_odd_o`=1, in the cycle right after the even pixel unless a strobe intervenes. It carries the odd Y and the same Cb and Cr as the even pixel.
- R7: `out_pair_o` is 0 for the first pair after a strobe or after reset. It rises by one for each following pair, wraps modulo 2^IDX_W, and is the same for both pixels of a pair.
- R8: `mode_16_i` (0 = byte-serial, 1 = split-lane) is sampled only in a cycle with `sav_i` high. Its value in any other cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_16_i | input | 1 | Requested mode: 0 byte-serial, 1 split-lane; sampled with `sav_i` |
| sav_i | input | 1 | Start-of-active-video / timing-reset strobe |
| pix_i | input | 2*DW | Pixel bus; `[DW-1:0]` low lane, `[2*DW-1:DW]` high lane |
| out_valid_o | output | 1 | One-cycle strobe per output pixel; no back-pressure |
| out_odd_o | output | 1 | 0 for the even pixel of a pair, 1 for the odd pixel |
| out_pair_o | output | IDX_W | Pixel-pair index since the last strobe |
| out_y_o | output | DW | Luma of the output pixel |
| out_cb_o | output | DW | Cb of the output pixel |
| out_cr_o | output | DW | Cr of the output pixel |

## Verification
The bound checker watches the output cadence on every cycle:

- silence after a strobe;
- even followed by odd;
- no pixel right after an odd one;
- chroma and pair index held across the two pixels of a pair.

Only the bench's scenarios can show that the right bytes reach the right fields. The same applies to ignoring unused lanes and skipped cycles, to ignoring mode changes between strobes, to the reset default of byte-serial mode, and to pair-index wrap. The bench covers these by sweeping both modes with arithmetic byte patterns, noise on unused lanes, strobes in mid-pair and a line long enough to wrap the index.

// File: rtl/pxdemux_pkg.sv
package pxdemux_pkg;
  typedef enum logic {
    LANE_SERIAL = 1'b0,
    LANE_SPLIT  = 1'b1
  } lane_mode_e;

  localparam int PHASES  = 4;
  localparam int PHASE_W = $clog2(PHASES);

  typedef enum logic [PHASE_W-1:0] {
    PH_CB_GRAB = 2'd0,
    PH_Y_GRAB  = 2'd1,
    PH_EVEN    = 2'd2,
    PH_ODD     = 2'd3
  } phase_e;
endpackage

// File: rtl/pxdemux_seq.sv
module pxdemux_seq
  import pxdemux_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sav_i,
  input  logic             mode_req_i,
  output lane_mode_e       mode_o,
  output phase_e           phase_o,
  output logic [IDX_W-1:0] pair_o
);
  lane_mode_e       mode_q;
  phase_e           phase_q;
  logic [IDX_W-1:0] pair_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= LANE_SERIAL;
      phase_q <= PH_CB_GRAB;
      pair_q  <= '0;
    end else if (sav_i) begin
      mode_q  <= lane_mode_e'(mode_req_i);
      phase_q <= PH_CB_GRAB;
      pair_q  <= '0;
    end else begin
      phase_q <= phase_e'(phase_q + 1'b1);
      if (phase_q == PH_ODD) pair_q <= pair_q + 1'b1;
    end
  end

  assign mode_o  = mode_q;
  assign phase_o = phase_q;
  assign pair_o  = pair_q;
endmodule

// File: rtl/pxdemux_path.sv
module pxdemux_path
  import pxdemux_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IDX_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  lane_mode_e        mode_i,
  input  phase_e            phase_i,
  input  logic [IDX_W-1:0]  pair_i,
  input  logic [2*DW-1:0]   pix_i,
  output logic              valid_o,
  output logic              odd_o,
  output logic [IDX_W-1:0]  pair_o,
  output logic [DW-1:0]     y_o,
  output logic [DW-1:0]     cb_o,
  output logic [DW-1:0]     cr_o
);
  logic [DW-1:0] lo_lane, hi_lane, chroma_in;
  logic [DW-1:0] cb_hold, y_hold;
  logic          split;

  assign lo_lane   = pix_i[DW-1:0];
  assign hi_lane   = pix_i[2*DW-1:DW];
  assign split     = (mode_i == LANE_SPLIT);
  assign chroma_in = split ? hi_lane : lo_lane;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cb_hold <= '0;
      y_hold  <= '0;
      valid_o <= 1'b0;
      odd_o   <= 1'b0;
      pair_o  <= '0;
      y_o     <= '0;
      cb_o    <= '0;
      cr_o    <= '0;
    end else begin
      valid_o <= 1'b0;
      if (step_i) begin
        unique case (phase_i)
          PH_CB_GRAB: begin
            cb_hold <= chroma_in;
            if (split) y_hold <= lo_lane;
          end
          PH_Y_GRAB: begin
            if (!split) y_hold <= lo_lane;
          end
          PH_EVEN: begin
            valid_o <= 1'b1;
            odd_o   <= 1'b0;
            pair_o  <= pair_i;
            y_o     <= y_hold;
            cb_o    <= cb_hold;
            cr_o    <= chroma_in;
            if (split) y_hold <= lo_lane;
          end
          PH_ODD: begin
            valid_o <= 1'b1;
            odd_o   <= 1'b1;
            pair_o  <= pair_i;
            y_o     <= split ? y_hold : lo_lane;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pxdemux.sv
module pxdemux
  import pxdemux_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_16_i,
  input  logic             sav_i,
  input  logic [2*DW-1:0]  pix_i,
  output logic             out_valid_o,
  output logic             out_odd_o,
  output logic [IDX_W-1:0] out_pair_o,
  output logic [DW-1:0]    out_y_o,
  output logic [DW-1:0]    out_cb_o,
  output logic [DW-1:0]    out_cr_o
);
  lane_mode_e       mode_act;
  phase_e           phase;
  logic [IDX_W-1:0] pair_cnt;

  pxdemux_seq #(.IDX_W(IDX_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sav_i      (sav_i),
    .mode_req_i (mode_16_i),
    .mode_o     (mode_act),
    .phase_o    (phase),
    .pair_o     (pair_cnt)
  );

  pxdemux_path #(.DW(DW), .IDX_W(IDX_W)) path_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (!sav_i),
    .mode_i  (mode_act),
    .phase_i (phase),
    .pair_i  (pair_cnt),
    .pix_i   (pix_i),
    .valid_o (out_valid_o),
    .odd_o   (out_odd_o),
    .pair_o  (out_pair_o),
    .y_o     (out_y_o),
    .cb_o    (out_cb_o),
    .cr_o    (out_cr_o)
  );
endmodule

// File: rtl/pxdemux_chk.sv
module pxdemux_chk #(
  parameter int DW    = 8,
  parameter int IDX_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sav_i,
  input logic             out_valid_o,
  input logic             out_odd_o,
  input logic [IDX_W-1:0] out_pair_o,
  input logic [DW-1:0]    out_cb_o,
  input logic [DW-1:0]    out_cr_o
);
  p_quiet_after_sav_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sav_i |=> !out_valid_o);

  p_even_then_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_odd_o && !sav_i) |=> (out_valid_o && out_odd_o));

  p_odd_has_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_odd_o) |-> $past(out_valid_o && !out_odd_o));

  p_gap_after_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_odd_o) |=> !out_valid_o);

  p_chroma_shared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_odd_o) |-> ($stable(out_cb_o) && $stable(out_cr_o)));

  p_pair_idx_shared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_odd_o) |-> $stable(out_pair_o));
endmodule

bind pxdemux pxdemux_chk #(.DW(DW), .IDX_W(IDX_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sav_i       (sav_i),
  .out_valid_o (out_valid_o),
  .out_odd_o   (out_odd_o),
  .out_pair_o  (out_pair_o),
  .out_cb_o    (out_cb_o),
  .out_cr_o    (out_cr_o)
);

// File: tb/pxdemux_tb_top.sv
`timescale 1ns/1ps
module pxdemux_tb_top;
  localparam int DW    = 8;
  localparam int IDX_W = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_16_i = 1'b0;
  logic             sav_i = 1'b0;
  logic [2*DW-1:0]  pix_i = '0;
  logic             out_valid_o, out_odd_o;
  logic [IDX_W-1:0] out_pair_o;
  logic [DW-1:0]    out_y_o, out_cb_o, out_cr_o;

  int vectors = 0;
  int misses  = 0;

  always #10 clk = ~clk;

  pxdemux #(.DW(DW), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_16_i(mode_16_i), .sav_i(sav_i),
    .pix_i(pix_i), .out_valid_o(out_valid_o), .out_odd_o(out_odd_o),
    .out_pair_o(out_pair_o), .out_y_o(out_y_o), .out_cb_o(out_cb_o),
    .out_cr_o(out_cr_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] cval(input int line, input int k);
    return 8'((line * 53 + k * 29 + 7) & 255);
  endfunction

  function automatic logic [7:0] noise(input int line, input int k);
    return 8'((line * 91 + k * 113 + 201) & 255);
  endfunction

  // Drive one cycle at a falling edge; return at the next falling edge,
  // when outputs reflect the rising edge that sampled these inputs.
  task automatic cycle(input logic sav, input logic mode_pin, input logic [15:0] bus);
    sav_i = sav;
    mode_16_i = mode_pin;
    pix_i = bus;
    @(negedge clk);
  endtask

  task automatic strobe(input logic mode_req, input int line, input string req);
    cycle(1'b1, mode_req, {noise(line, 1), noise(line, 2)});
    chk(out_valid_o == 1'b0, req, out_valid_o, 0);
  endtask

  // One pixel pair; mode_pin is the value on mode_16_i, split is the active mode.
  task automatic run_pair(input int line, input int p, input bit split,
                          input logic mode_pin, input string req);
    logic [7:0] cb, y0, cr, y1;
    int exp_idx;
    cb = cval(line, 4*p); y0 = cval(line, 4*p+1);
    cr = cval(line, 4*p+2); y1 = cval(line, 4*p+3);
    exp_idx = p % (1 << IDX_W);
    cycle(1'b0, mode_pin, split ? {cb, y0} : {noise(line, p), cb});
    chk(out_valid_o == 1'b0, {req, " R4 quiet ph0"}, out_valid_o, 0);
    cycle(1'b0, mode_pin, split ? {noise(line, p+3), noise(line, p+5)} : {noise(line, p+1), y0});
    chk(out_valid_o == 1'b0, {req, " R4 quiet ph1"}, out_valid_o, 0);
    cycle(1'b0, mode_pin, split ? {cr, y1} : {noise(line, p+2), cr});
    chk(out_valid_o == 1'b1 && out_odd_o == 1'b0, {req, " R5 even strobe"}, {out_valid_o, out_odd_o}, 2);
    chk(out_y_o == y0, {req, " R5 even Y"}, out_y_o, y0);
    chk(out_cb_o == cb, {req, " R5 even Cb"}, out_cb_o, cb);
    chk(out_cr_o == cr, {req, " R5 even Cr"}, out_cr_o, cr);
    chk(out_pair_o == exp_idx[IDX_W-1:0], {req, " R7 even idx"}, out_pair_o, exp_idx);
    cycle(1'b0, mode_pin, split ? {noise(line, p+7), noise(line, p+9)} : {noise(line, p+4), y1});
    chk(out_valid_o == 1'b1 && out_odd_o == 1'b1, {req, " R6 odd strobe"}, {out_valid_o, out_odd_o}, 3);
    chk(out_y_o == y1, {req, " R6 odd Y"}, out_y_o, y1);
    chk(out_cb_o == cb && out_cr_o == cr, {req, " R6 odd chroma"}, {out_cb_o, out_cr_o}, {cb, cr});
    chk(out_pair_o == exp_idx[IDX_W-1:0], {req, " R7 odd idx"}, out_pair_o, exp_idx);
  endtask

  initial begin
    #(200000 * 20);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk(out_valid_o == 1'b0, "R1 valid in reset", out_valid_o, 0);
    chk(out_y_o == 0 && out_cb_o == 0 && out_cr_o == 0, "R1 data in reset",
        {out_y_o, out_cb_o, out_cr_o}, 0);
    rst_n = 1'b1;
    // R1/R8: byte-serial default right after reset, mode pin high but ignored
    for (int p = 0; p < 3; p++) run_pair(0, p, 1'b0, 1'b1, "R1 R8 R2 default");
    // R3/R8: split-lane line, mode pin toggled mid-line without effect
    strobe(1'b1, 1, "R4 sav split");
    for (int p = 0; p < 4; p++) run_pair(1, p, 1'b1, 1'(p & 1), "R3 R8 split");
    // R2: byte-serial line with high-lane noise and mode pin high
    strobe(1'b0, 2, "R4 sav serial");
    for (int p = 0; p < 4; p++) run_pair(2, p, 1'b0, 1'b1, "R2 R8 serial");
    // R4: strobe in mid-pair realigns
    strobe(1'b0, 3, "R4 sav");
    cycle(1'b0, 1'b0, 16'h1234);
    cycle(1'b0, 1'b0, 16'h5678);
    strobe(1'b1, 4, "R4 mid-pair sav");
    for (int p = 0; p < 3; p++) run_pair(4, p, 1'b1, 1'b0, "R4 R3 realign");
    strobe(1'b1, 5, "R4 sav");
    cycle(1'b0, 1'b1, 16'h9abc);
    strobe(1'b0, 6, "R4 mid-pair sav");
    for (int p = 0; p < 2; p++) run_pair(6, p, 1'b0, 1'b1, "R4 R2 realign");
    // R7: index wrap in a long byte-serial line
    strobe(1'b0, 7, "R4 sav");
    for (int p = 0; p < (1 << IDX_W) + 3; p++) run_pair(7, p, 1'b0, 1'b0, "R7 wrap");
    // R7: a long split-lane line too, smaller
    strobe(1'b1, 8, "R4 sav");
    for (int p = 0; p < 40; p++) run_pair(8, p, 1'b1, 1'b1, "R7 R3 split run");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule